// File: doc/BRIEF.md
# Packed SIMD Right Shift Unit

This unit is a purely combinational datapath. It shifts every lane of a 64-bit word right by the same amount. The word is split either into four 16-bit lanes or into two 32-bit lanes. Each lane is shifted either logically, filling with zeros, or arithmetically, filling with copies of the lane's top bit. No bit ever moves from one lane into another.

The shift amount comes from one of two sources: a 5-bit immediate, or the whole 64-bit value of a second register operand read as unsigned. The amount saturates at the lane width; it never wraps.

Each operand carries a poison flag, and the unit merges these flags into the result. A qualifying predicate gates the write. An illegal destination index raises a fault and blocks the write. Instruction decode, the register file and any pipelining are handled outside the unit.

Top module: `packedShiftRight`

## Requirements
- R1: With `laneWide`=0, the word is four 16-bit lanes at bits 15:0, 31:16, 47:32 and 63:48. Each lane is shifted right by the effective count.
- R2: With `laneWide`=1, the word is two 32-bit lanes at bits 31:0 and 63:32. Each lane is shifted right by the effective count.
- R3: With `isSigned`=1, vacated lane bits take the lane's top bit. With `isSigned`=0, they are zero.
- R4: In 16-bit lane mode, any count above 16 acts as 16. A saturated lane becomes all zeros when logical, or all copies of its sign bit when arithmetic.
- R5: In 32-bit lane mode, any count above 32 acts as 32, with the same fill rule as R4.
- R6: With `useVariable`=0, the count is `countImm` (0 to 31). With `useVariable`=1, the count is all 64 bits of `countReg` read as unsigned, so high bits never wrap the count to a small value.
- R7: `resultPoison` equals `srcPoison` OR (`countPoison` AND `useVariable`).
- R8: When `predicate`=0, `writeEn`=0 and `illegalFault`=0 for any destination index.
- R9: When `predicate`=1, `illegalFault`=1 if `destIdx` is 0 or is 96 or more (96 registers are implemented). In that case `writeEn`=0; otherwise `writeEn`=1.
- R10: Each result lane depends only on the bits of the same source lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcData | input | 64 | Data operand to be shifted |
| srcPoison | input | 1 | Poison flag of the data operand |
| countReg | input | 64 | Register count operand (variable form) |
| countPoison | input | 1 | Poison flag of the count operand |
| countImm | input | 5 | Immediate count (immediate form) |
| useVariable | input | 1 | 1 selects countReg, 0 selects countImm |
| laneWide | input | 1 | 0 = 16-bit lanes, 1 = 32-bit lanes |
| isSigned | input | 1 | 1 = arithmetic shift, 0 = logical shift |
| predicate | input | 1 | Qualifying predicate |
| destIdx | input | 7 | Destination register index |
| result | output | 64 | Shifted word |
| resultPoison | output | 1 | Merged poison flag |
| writeEn | output | 1 | Destination write strobe |
| illegalFault | output | 1 | Illegal destination fault |

## Verification
The hardest case to reach is a register count that is huge but has small low bits, such as 2^32+3. A design that truncates the count would see it as 3 instead of saturating. The stimulus sweeps every count from 0 to 63 under both lane widths, both fill modes and both count sources, using data whose lanes have their sign bits set. It then adds register counts that carry set high bits above small low values. Lane isolation is tested with data whose neighbouring lanes differ sharply in sign, so that any leak across a lane edge shows up in the fill bits.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int DATA_W   = 64;
  localparam int NARROW_W = 16;
  localparam int WIDE_W   = 32;
  localparam int IMM_W    = 5;
  localparam int AMT_W    = $clog2(WIDE_W) + 1;
  localparam int IDX_W    = 7;

  typedef struct packed {
    logic             laneWide;
    logic             arith;
    logic [AMT_W-1:0] shiftAmt;
    logic             writeEn;
    logic             poison;
    logic             fault;
  } shrStrobes_t;
endpackage

// File: rtl/shrCtrl.sv
module shrCtrl
  import shr_pkg::*;
#(
  parameter int NUM_REGS = 96
) (
  input  logic [DATA_W-1:0] countReg,
  input  logic              countPoison,
  input  logic [IMM_W-1:0]  countImm,
  input  logic              useVariable,
  input  logic              laneWide,
  input  logic              isSigned,
  input  logic              srcPoison,
  input  logic              predicate,
  input  logic [IDX_W-1:0]  destIdx,
  output shrStrobes_t       strobes
);
  localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(NUM_REGS - 1);
  localparam logic [DATA_W-1:0] NARROW_LIM = DATA_W'(NARROW_W);
  localparam logic [DATA_W-1:0] WIDE_LIM   = DATA_W'(WIDE_W);

  logic [DATA_W-1:0] rawCount;
  logic [DATA_W-1:0] laneLimit;
  logic [AMT_W-1:0]  effAmt;
  logic              badTarget;

  // Count source: the register count is taken whole and unsigned.
  assign rawCount  = useVariable ? countReg : DATA_W'(countImm);
  assign laneLimit = laneWide ? WIDE_LIM : NARROW_LIM;

  // Saturate the count at the lane width.
  always_comb begin
    if (rawCount > laneLimit) effAmt = laneLimit[AMT_W-1:0];
    else                      effAmt = rawCount[AMT_W-1:0];
  end

  assign badTarget = (destIdx == '0) || (destIdx > LAST_IDX);

  always_comb begin
    strobes.laneWide = laneWide;
    strobes.arith    = isSigned;
    strobes.shiftAmt = effAmt;
    strobes.poison   = srcPoison | (useVariable & countPoison);
    strobes.fault    = predicate & badTarget;
    strobes.writeEn  = predicate & ~badTarget;
  end
endmodule

// File: rtl/shrDatapath.sv
module shrDatapath
  import shr_pkg::*;
(
  input  logic [DATA_W-1:0] srcData,
  input  shrStrobes_t       strobes,
  output logic [DATA_W-1:0] result
);
  localparam int N_NARROW = DATA_W / NARROW_W;
  localparam int N_WIDE   = DATA_W / WIDE_W;

  logic [DATA_W-1:0] narrowRes;
  logic [DATA_W-1:0] wideRes;

  for (genvar g = 0; g < N_NARROW; g++) begin : gNarrow
    logic        [NARROW_W-1:0] laneIn;
    logic        [NARROW_W-1:0] logicOut;
    logic signed [NARROW_W-1:0] arithOut;
    assign laneIn   = srcData[g*NARROW_W +: NARROW_W];
    assign logicOut = laneIn >> strobes.shiftAmt;
    assign arithOut = $signed(laneIn) >>> strobes.shiftAmt;
    assign narrowRes[g*NARROW_W +: NARROW_W] =
      strobes.arith ? $unsigned(arithOut) : logicOut;
  end

  for (genvar g = 0; g < N_WIDE; g++) begin : gWide
    logic        [WIDE_W-1:0] laneIn;
    logic        [WIDE_W-1:0] logicOut;
    logic signed [WIDE_W-1:0] arithOut;
    assign laneIn   = srcData[g*WIDE_W +: WIDE_W];
    assign logicOut = laneIn >> strobes.shiftAmt;
    assign arithOut = $signed(laneIn) >>> strobes.shiftAmt;
    assign wideRes[g*WIDE_W +: WIDE_W] =
      strobes.arith ? $unsigned(arithOut) : logicOut;
  end

  assign result = strobes.laneWide ? wideRes : narrowRes;
endmodule

// File: rtl/packedShiftRight.sv
module packedShiftRight
  import shr_pkg::*;
#(
  parameter int NUM_REGS = 96
) (
  input  logic [DATA_W-1:0] srcData,
  input  logic              srcPoison,
  input  logic [DATA_W-1:0] countReg,
  input  logic              countPoison,
  input  logic [IMM_W-1:0]  countImm,
  input  logic              useVariable,
  input  logic              laneWide,
  input  logic              isSigned,
  input  logic              predicate,
  input  logic [IDX_W-1:0]  destIdx,
  output logic [DATA_W-1:0] result,
  output logic              resultPoison,
  output logic              writeEn,
  output logic              illegalFault
);
  shrStrobes_t strobes;

  shrCtrl #(.NUM_REGS(NUM_REGS)) uCtrl (
    .countReg    (countReg),
    .countPoison (countPoison),
    .countImm    (countImm),
    .useVariable (useVariable),
    .laneWide    (laneWide),
    .isSigned    (isSigned),
    .srcPoison   (srcPoison),
    .predicate   (predicate),
    .destIdx     (destIdx),
    .strobes     (strobes)
  );

  shrDatapath uDp (
    .srcData (srcData),
    .strobes (strobes),
    .result  (result)
  );

  assign resultPoison = strobes.poison;
  assign writeEn      = strobes.writeEn;
  assign illegalFault = strobes.fault;
endmodule

// File: rtl/packedShiftRight_chk.sv
module packedShiftRight_chk
  import shr_pkg::*;
(
  input logic [DATA_W-1:0] srcData,
  input logic              srcPoison,
  input logic [DATA_W-1:0] countReg,
  input logic              countPoison,
  input logic              useVariable,
  input logic              laneWide,
  input logic              isSigned,
  input logic              predicate,
  input logic [DATA_W-1:0] result,
  input logic              resultPoison,
  input logic              writeEn,
  input logic              illegalFault
);
  always_comb begin
    // R8: a false predicate neither writes nor faults
    if (!predicate)
      p_no_write_r8: assert (!writeEn && !illegalFault);
    // R9: a fault and a write never coincide
    p_fault_excl_r9: assert (!(writeEn && illegalFault));
    // R7: the immediate form ignores the count poison
    if (!useVariable)
      p_imm_poison_r7: assert (resultPoison == srcPoison);
    // R7: any poisoned data operand poisons the result
    if (srcPoison)
      p_src_poison_r7: assert (resultPoison);
    // R4: a saturated logical shift of 16-bit lanes clears them
    if (useVariable && !laneWide && !isSigned && countReg >= 64'd16)
      p_clamp16_r4: assert (result == '0);
    // R5, R3: a saturated arithmetic shift of 32-bit lanes fills with sign
    if (useVariable && laneWide && isSigned && countReg >= 64'd32)
      p_clamp32_r5: assert (result == {{32{srcData[63]}}, {32{srcData[31]}}});
  end
endmodule

bind packedShiftRight packedShiftRight_chk uChk (
  .srcData      (srcData),
  .srcPoison    (srcPoison),
  .countReg     (countReg),
  .countPoison  (countPoison),
  .useVariable  (useVariable),
  .laneWide     (laneWide),
  .isSigned     (isSigned),
  .predicate    (predicate),
  .result       (result),
  .resultPoison (resultPoison),
  .writeEn      (writeEn),
  .illegalFault (illegalFault)
);

// File: tb/packedShiftRight_test.sv
`timescale 1ns/1ps
module packedShiftRight_test;
  logic        clk = 1'b0;
  logic [63:0] srcData = '0;
  logic        srcPoison = 1'b0;
  logic [63:0] countReg = '0;
  logic        countPoison = 1'b0;
  logic [4:0]  countImm = '0;
  logic        useVariable = 1'b0;
  logic        laneWide = 1'b0;
  logic        isSigned = 1'b0;
  logic        predicate = 1'b0;
  logic [6:0]  destIdx = '0;
  logic [63:0] result;
  logic        resultPoison, writeEn, illegalFault;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  packedShiftRight uut (
    .srcData(srcData), .srcPoison(srcPoison), .countReg(countReg),
    .countPoison(countPoison), .countImm(countImm), .useVariable(useVariable),
    .laneWide(laneWide), .isSigned(isSigned), .predicate(predicate),
    .destIdx(destIdx), .result(result), .resultPoison(resultPoison),
    .writeEn(writeEn), .illegalFault(illegalFault)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Bit-level reference built from the requirements.
  function automatic logic [63:0] refShift(logic [63:0] d, logic wide,
                                           logic sgn, logic [63:0] cnt);
    logic [63:0] r;
    int lw, amt;
    lw  = wide ? 32 : 16;
    amt = (cnt > 64'(lw)) ? lw : int'(cnt);
    for (int base = 0; base < 64; base += lw)
      for (int i = 0; i < lw; i++)
        if (i + amt < lw) r[base+i] = d[base+i+amt];
        else              r[base+i] = sgn ? d[base+lw-1] : 1'b0;
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic testReset();
    settle();
    check("R8 idle result", result, 64'h0);
    check("R8 idle writeEn", {63'h0, writeEn}, 64'h0);
    check("R8 idle fault", {63'h0, illegalFault}, 64'h0);
  endtask

  task automatic sweep(logic [63:0] d);
    predicate = 1'b1;
    destIdx = 7'd5;
    srcData = d;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 64; c++) begin
          laneWide = w[0];
          isSigned = s[0];
          useVariable = 1'b1;
          countReg = 64'(c);
          settle();
          check(w ? (c > 32 ? "R5 var" : "R2 var") : (c > 16 ? "R4 var" : "R1 var"),
                result, refShift(d, w[0], s[0], 64'(c)));
          if (s != 0 && c > 0)
            check("R3 var fill", result, refShift(d, w[0], 1'b1, 64'(c)));
          if (c < 32) begin
            useVariable = 1'b0;
            countImm = 5'(c);
            countReg = 64'hDEAD_BEEF_0000_0001;
            settle();
            check("R6 imm", result, refShift(d, w[0], s[0], 64'(c)));
          end
        end
  endtask

  task automatic testHugeCounts();
    srcData = 64'h8123_7456_C789_0ABC;
    useVariable = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++) begin
        laneWide = w[0];
        isSigned = s[0];
        countReg = 64'h0000_0001_0000_0003;
        settle();
        check("R6 huge low3", result, refShift(srcData, w[0], s[0], 64'd40));
        countReg = 64'hFFFF_FFFF_FFFF_FFF0;
        settle();
        check("R6 negative-looking", result, refShift(srcData, w[0], s[0], 64'd40));
      end
  endtask

  task automatic testLaneIsolation();
    useVariable = 1'b0;
    isSigned = 1'b1;
    laneWide = 1'b0;
    srcData = 64'h0001_FFFF_0000_8000;
    countImm = 5'd4;
    settle();
    check("R10 narrow", result, 64'h0000_FFFF_0000_F800);
    laneWide = 1'b1;
    srcData = 64'h0000_0001_8000_0000;
    countImm = 5'd8;
    settle();
    check("R10 wide", result, 64'h0000_0000_FF80_0000);
    isSigned = 1'b0;
    settle();
    check("R10 wide logical", result, 64'h0000_0000_0080_0000);
  endtask

  task automatic testPoison();
    for (int k = 0; k < 8; k++) begin
      srcPoison = k[0];
      countPoison = k[1];
      useVariable = k[2];
      settle();
      check("R7 poison", {63'h0, resultPoison},
            {63'h0, k[0] | (k[1] & k[2])});
    end
    srcPoison = 1'b0;
    countPoison = 1'b0;
  endtask

  task automatic testPredFault();
    logic [6:0] idxs [5] = '{7'd0, 7'd1, 7'd95, 7'd96, 7'd127};
    logic       badIdx [5] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    for (int i = 0; i < 5; i++) begin
      destIdx = idxs[i];
      predicate = 1'b1;
      settle();
      check("R9 fault", {63'h0, illegalFault}, {63'h0, badIdx[i]});
      check("R9 writeEn", {63'h0, writeEn}, {63'h0, ~badIdx[i]});
      predicate = 1'b0;
      settle();
      check("R8 pred off fault", {63'h0, illegalFault}, 64'h0);
      check("R8 pred off writeEn", {63'h0, writeEn}, 64'h0);
    end
  endtask

  initial begin
    testReset();
    sweep(64'h8001_7FFF_C3A5_0F0F);
    sweep(64'hF000_0000_8765_4321);
    testHugeCounts();
    testLaneIsolation();
    testPoison();
    testPredFault();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule